// File: doc/BRIEF.md
# Multiplexed Segment Memory Loader

This block keeps the on/off pattern of a segment LCD in a 40-word, 4-bit memory. Word address n drives segment line n. Bit k of each word is the state that segment takes while backplane k is active. A stored 1 lights the segment and a stored 0 leaves it dark. A backplane scanner elsewhere reads one word at a time through a combinational read port.

Display data arrives one byte at a time on a write strobe. A 2-bit drive-mode select picks how many backplanes the panel uses: static, 1:2, 1:3 or 1:4. That number of lanes sets how the eight bits of the byte are spread over consecutive words.

- The byte is used from its most significant bit down.
- Each word fills from lane 0 upward before the next word is started.
- An internal address pointer, which software can preset through a load port, moves on by one for every word touched. It wraps from the last word back to word 0, even in the middle of a byte.

The scatter takes one clock per word. A busy output covers those cycles, and while it is high the block ignores new strobes and pointer loads.

Top module: `segmap_loader`

## Requirements
- R1: After reset every memory word reads 0, the pointer is 0 and `busy` is low.
- R2: With mode code 0 (static), byte bit 7-c is written to lane 0 of word pointer+c for c = 0..7, and lanes 1 to 3 of those words keep their values.
- R3: With mode code 1 (two lanes), bit 7-c goes to lane c mod 2 of word pointer+c/2, so four words are filled, and lanes 2 and 3 keep their values.
- R4: With mode code 2 (three lanes), bit 7-c goes to lane c mod 3 of word pointer+c/3. The third word receives only lanes 0 and 1, and its lane 2 keeps its previous value, as does lane 3 of every word.
- R5: With mode code 3 (four lanes), byte bits 7..4 go to lanes 0..3 of word pointer, and bits 3..0 go to lanes 0..3 of word pointer+1.
- R6: After a byte the pointer has moved by 8, 4, 3 or 2 words (mode codes 0..3), so the next byte continues from there. Word addresses wrap from 39 to 0, including in the middle of a byte.
- R7: `busy` rises on the clock edge that accepts a strobe and stays high for exactly 8, 4, 3 or 2 cycles (mode codes 0..3).
- R8: While `busy` is high, `wr_stb`, `ptr_ld`, `wr_byte`, `mode_sel` and `ptr_val` have no effect on the memory or the pointer.
- R9: A pointer load while idle sets the pointer to `ptr_val`, or to 0 when `ptr_val` is 40 or more. A strobe in the same cycle as a load is ignored.
- R10: `rd_word` shows the word at `rd_addr` in the same cycle. For `rd_addr` of 40 or more it reads 0.
- R11: At most one word changes per clock. One cycle after the accepting edge only the word at the starting pointer has been updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Presents a display byte for loading |
| wr_byte | input | 8 | Display byte |
| mode_sel | input | 2 | Drive mode code: 0 static, 1 two lanes, 2 three lanes, 3 four lanes |
| ptr_ld | input | 1 | Loads the address pointer from `ptr_val` |
| ptr_val | input | 6 | Starting word address |
| busy | output | 1 | High while a byte is being scattered |
| rd_addr | input | 6 | Scanner read address |
| rd_word | output | 4 | Word at `rd_addr`, one bit per backplane |

## Verification
The hardest case to reach from the ports is a three-lane byte whose short last word lands on word 39 or word 0 after a wrap. That case has to show that lane 2 was left alone while the pointer crossed the end of memory. The bench reaches it by sending all 256 byte values in every mode back to back. Each run starts from a preset pointer near the top of memory, so the 3-word stride walks the wrap point through every offset. After every byte the whole memory is compared with an arithmetic model. Some bytes carry strobes, loads and mode changes while busy, and one static byte is sampled halfway through to show the one-word-per-clock progress.

// File: rtl/segmap_pkg.sv
package segmap_pkg;

   // Drive-mode codes; the code plus one is the number of lanes per word.
   typedef enum logic [1:0] {
      DRV_STATIC = 2'd0,
      DRV_DUAL   = 2'd1,
      DRV_TRIPLE = 2'd2,
      DRV_QUAD   = 2'd3
   } drive_mode_e;

   function automatic int lanes_of(input int mode_code);
      return mode_code + 1;
   endfunction

   function automatic int words_per_byte(input int byte_w, input int lanes);
      return (byte_w + lanes - 1) / lanes;
   endfunction

endpackage

// File: rtl/segmap_scatter.sv
// Splits one captured byte into per-word lane writes, one word per clock.
module segmap_scatter #(
   parameter int BYTE_W = 8,
   parameter int WIDTH  = 4,
   parameter int MODE_W = 2,
   localparam int CNT_W = $clog2(BYTE_W + 1),
   localparam int LN_W  = $clog2(WIDTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [MODE_W-1:0] mode,
   input  logic [BYTE_W-1:0] byte_in,
   output logic              busy,
   output logic              wr_en,
   output logic [WIDTH-1:0]  wr_mask,
   output logic [WIDTH-1:0]  wr_data
);

   if (WIDTH > BYTE_W) begin : g_bad_width
      $error("segmap_scatter: WIDTH must not exceed BYTE_W");
   end
   if (CNT_W < LN_W) begin : g_bad_cnt
      $error("segmap_scatter: counter narrower than lane count");
   end

   logic [BYTE_W-1:0] sh_q;
   logic [CNT_W-1:0]  rem_q;
   logic [LN_W-1:0]   ln_q;
   logic [CNT_W-1:0]  take;

   assign busy  = |rem_q;
   assign wr_en = busy;

   // Bits consumed this cycle: a full word of lanes, or what is left.
   always_comb begin
      if (CNT_W'(ln_q) < rem_q) take = CNT_W'(ln_q);
      else                      take = rem_q;
   end

   for (genvar j = 0; j < WIDTH; j++) begin : g_lane
      assign wr_mask[j] = busy && (CNT_W'(j) < take);
      assign wr_data[j] = sh_q[BYTE_W-1-j];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q  <= '0;
         rem_q <= '0;
         ln_q  <= '0;
      end else if (start) begin
         sh_q  <= byte_in;
         rem_q <= CNT_W'(BYTE_W);
         ln_q  <= LN_W'(mode) + LN_W'(1);
      end else if (busy) begin
         sh_q  <= sh_q << take;
         rem_q <= rem_q - take;
      end
   end

endmodule

// File: rtl/segmap_ptr.sv
// Word address pointer with load, advance and wrap at DEPTH.
module segmap_ptr #(
   parameter int DEPTH  = 40,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [ADDR_W-1:0] ld_val,
   input  logic              adv,
   output logic [ADDR_W-1:0] ptr
);

   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] nxt;
   logic              val_ok;

   assign ptr    = ptr_q;
   assign val_ok = {1'b0, ld_val} < (ADDR_W + 1)'(DEPTH);

   if (DEPTH == (1 << ADDR_W)) begin : g_pow2
      assign nxt = ptr_q + 1'b1;
   end else begin : g_cmp
      assign nxt = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   ptr_q <= '0;
      else if (ld)  ptr_q <= val_ok ? ld_val : '0;
      else if (adv) ptr_q <= nxt;
   end

endmodule

// File: rtl/segmap_store.sv
// Segment memory with per-lane write mask and combinational read.
module segmap_store #(
   parameter int DEPTH  = 40,
   parameter int WIDTH  = 4,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WIDTH-1:0]  wmask,
   input  logic [WIDTH-1:0]  wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WIDTH-1:0]  rdata
);

   logic [DEPTH*WIDTH-1:0] flat;

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      logic [WIDTH-1:0] cell_q;
      logic             hit;
      assign hit = we && (waddr == ADDR_W'(w));
      always_ff @(posedge clk) begin
         if (!rst_n)   cell_q <= '0;
         else if (hit) cell_q <= (cell_q & ~wmask) | (wdata & wmask);
      end
      assign flat[w*WIDTH +: WIDTH] = cell_q;
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (raddr == ADDR_W'(i)) rdata = flat[i*WIDTH +: WIDTH];
      end
   end

endmodule

// File: rtl/segmap_loader.sv
// Top: multiplex-aware display memory loader.
module segmap_loader #(
   parameter int DEPTH  = 40,
   parameter int WIDTH  = 4,
   parameter int BYTE_W = 8,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int MODE_W = $clog2(WIDTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [BYTE_W-1:0] wr_byte,
   input  logic [MODE_W-1:0] mode_sel,
   input  logic              ptr_ld,
   input  logic [ADDR_W-1:0] ptr_val,
   output logic              busy,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WIDTH-1:0]  rd_word
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("segmap_loader: DEPTH must be at least 2");
   end
   if (WIDTH < 2 || (1 << MODE_W) != WIDTH) begin : g_bad_lanes
      $error("segmap_loader: WIDTH must be a power of two >= 2");
   end

   logic              accept;
   logic              ld_ok;
   logic              wr_en;
   logic [WIDTH-1:0]  wr_mask;
   logic [WIDTH-1:0]  wr_data;
   logic [ADDR_W-1:0] ptr_q;

   assign accept = wr_stb && !busy && !ptr_ld;
   assign ld_ok  = ptr_ld && !busy;

   segmap_scatter #(.BYTE_W(BYTE_W), .WIDTH(WIDTH), .MODE_W(MODE_W)) u_scatter (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (accept),
      .mode    (mode_sel),
      .byte_in (wr_byte),
      .busy    (busy),
      .wr_en   (wr_en),
      .wr_mask (wr_mask),
      .wr_data (wr_data)
   );

   segmap_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (ld_ok),
      .ld_val (ptr_val),
      .adv    (wr_en),
      .ptr    (ptr_q)
   );

   segmap_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en),
      .waddr (ptr_q),
      .wmask (wr_mask),
      .wdata (wr_data),
      .raddr (rd_addr),
      .rdata (rd_word)
   );

endmodule

// File: rtl/segmap_loader_chk.sv
module segmap_loader_chk #(
   parameter int DEPTH  = 40,
   parameter int WIDTH  = 4,
   parameter int BYTE_W = 8,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int MODE_W = $clog2(WIDTH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_stb,
   input logic              ptr_ld,
   input logic [MODE_W-1:0] mode_sel,
   input logic              busy,
   input logic [ADDR_W-1:0] ptr,
   input logic              wr_en,
   input logic [WIDTH-1:0]  wr_mask
);

   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

   int cnt_q;
   int exp_q;
   int lanes_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= 0;
         exp_q   <= 0;
         lanes_q <= 0;
      end else if (wr_stb && !busy && !ptr_ld) begin
         cnt_q   <= 0;
         lanes_q <= int'(mode_sel) + 1;
         exp_q   <= (BYTE_W + int'(mode_sel)) / (int'(mode_sel) + 1);
      end else if (busy) begin
         cnt_q <= cnt_q + 1;
      end
   end

   AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> cnt_q == exp_q); // R7

   AST_MASK_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ($countones(wr_mask) >= 1 && $countones(wr_mask) <= lanes_q)); // R4

   AST_MASK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ((wr_mask & (wr_mask + 1'b1)) == '0)); // R2

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)); // R6

   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !ptr_ld) |=> $stable(ptr)); // R9

   AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, ptr} < (ADDR_W + 1)'(DEPTH)); // R6

   AST_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ptr_ld) |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)); // R8

endmodule

bind segmap_loader segmap_loader_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .BYTE_W(BYTE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_stb   (wr_stb),
   .ptr_ld   (ptr_ld),
   .mode_sel (mode_sel),
   .busy     (busy),
   .ptr      (ptr_q),
   .wr_en    (wr_en),
   .wr_mask  (wr_mask)
);

// File: tb/segmap_loader_test.sv
`timescale 1ns/1ps
module segmap_loader_test;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       wr_stb;
   logic [7:0] wr_byte;
   logic [1:0] mode_sel;
   logic       ptr_ld;
   logic [5:0] ptr_val;
   logic       busy;
   logic [5:0] rd_addr;
   logic [3:0] rd_word;

   logic [3:0] model_mem [40];
   int model_ptr;
   int nvec = 0;
   int nbad = 0;

   always #4 clk = ~clk;

   segmap_loader uut (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_byte(wr_byte),
      .mode_sel(mode_sel), .ptr_ld(ptr_ld), .ptr_val(ptr_val),
      .busy(busy), .rd_addr(rd_addr), .rd_word(rd_word)
   );

   task automatic chk(input string tag, input int act, input int exp);
      nvec++;
      if (act != exp) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_byte(input int mode, input logic [7:0] b);
      int lanes = mode + 1;
      for (int c = 0; c < 8; c++) begin
         model_mem[(model_ptr + c / lanes) % 40][c % lanes] = b[7-c];
      end
      model_ptr = (model_ptr + (8 + mode) / lanes) % 40;
   endtask

   task automatic dump(input string tag);
      for (int a = 0; a < 40; a++) begin
         rd_addr = 6'(a);
         #1;
         chk($sformatf("%s word %0d", tag, a), int'(rd_word), int'(model_mem[a]));
      end
   endtask

   task automatic load_ptr(input int v);
      @(negedge clk);
      ptr_ld = 1'b1;
      ptr_val = 6'(v);
      @(negedge clk);
      ptr_ld = 1'b0;
      model_ptr = (v < 40) ? v : 0;
   endtask

   task automatic send(input int mode, input logic [7:0] b, input bit meddle, input string tag);
      int cnt = 0;
      @(negedge clk);
      mode_sel = 2'(mode);
      wr_byte  = b;
      wr_stb   = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0;
      if (meddle) begin
         wr_stb   = 1'b1;
         ptr_ld   = 1'b1;
         ptr_val  = 6'd5;
         wr_byte  = ~b;
         mode_sel = 2'(3 - mode);
      end
      while (busy) begin
         cnt++;
         @(negedge clk);
         wr_stb = 1'b0;
         ptr_ld = 1'b0;
      end
      chk($sformatf("R7 busy cycles mode %0d", mode), cnt, (8 + mode) / (mode + 1));
      model_byte(mode, b);
      dump(meddle ? "R8" : tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      logic [3:0] e10;
      logic [3:0] e11;
      rst_n = 1'b0; wr_stb = 1'b0; wr_byte = '0; mode_sel = '0;
      ptr_ld = 1'b0; ptr_val = '0; rd_addr = '0;
      for (int a = 0; a < 40; a++) model_mem[a] = '0;
      model_ptr = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy after reset", int'(busy), 0);
      dump("R1");

      // Near-exhaustive sweep: every byte value in every mode.
      for (int m = 0; m < 4; m++) begin
         for (int b = 0; b < 256; b++) begin
            string tg;
            if (b % 64 == 0) load_ptr(39 - m - (b / 64));
            case (m)
               0: tg = "R2 R6";
               1: tg = "R3 R6";
               2: tg = "R4 R6";
               default: tg = "R5 R6";
            endcase
            send(m, 8'(b), (b % 37) == 5, tg);
         end
      end

      // R9: out-of-range load goes to 0.
      load_ptr(45);
      send(3, 8'hA5, 1'b0, "R9");

      // R9: strobe together with load is ignored, load wins.
      @(negedge clk);
      ptr_ld = 1'b1; ptr_val = 6'd20; wr_stb = 1'b1; wr_byte = 8'hFF; mode_sel = 2'd0;
      @(negedge clk);
      ptr_ld = 1'b0; wr_stb = 1'b0;
      chk("R9 strobe with load ignored busy", int'(busy), 0);
      model_ptr = 20;
      dump("R9");
      send(1, 8'h3C, 1'b0, "R9 R3");

      // R10: out-of-range read returns zero.
      for (int a = 40; a < 64; a++) begin
         rd_addr = 6'(a);
         #1;
         chk($sformatf("R10 read %0d", a), int'(rd_word), 0);
      end

      // R11: one word per clock.
      load_ptr(10);
      e10 = (model_mem[10] & 4'hE) | 4'h1;
      e11 = model_mem[11];
      @(negedge clk);
      mode_sel = 2'd0; wr_byte = 8'h80; wr_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0;
      @(negedge clk);
      rd_addr = 6'd10; #0.5;
      chk("R11 first word written", int'(rd_word), int'(e10));
      rd_addr = 6'd11; #0.5;
      chk("R11 next word not yet", int'(rd_word), int'(e11));
      while (busy) @(negedge clk);
      model_byte(0, 8'h80);
      dump("R11");

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

endmodule